// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address used by load and store operations in a 16-bit processor core. The decode stage hands it operand values that have already been read from the register file, the raw immediate field of the instruction, and a two-bit selector naming one of three addressing forms. One clock later the block presents the effective address together with a valid flag.

The three forms are:
- a register plus a short immediate whose range is lopsided toward positive offsets;
- the sum of two registers, which is useful after an 8-bit signed constant has been loaded into one of them, because it reaches about 128 bytes either side of the stack pointer in two operations;
- a dedicated base-pointer register plus a signed 8-bit displacement.

The base pointer lives inside the block, outside the eight general-purpose registers, and has its own write port so software can point it at a stack frame.

Top module: `lsea_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ea_valid` is 0 and `ea_addr` is 0x0000. The base pointer resets to 0x0000, so a base-pointer request with displacement 0 issued after reset yields 0x0000.
- R2: A request accepted on a rising edge, meaning `req_valid` is 1 and `req_mode` is not 2'b11, gives `ea_valid` = 1 after that edge, with the address for that request. This is one cycle of latency.
- R3: With `req_mode` = 2'b00 (register plus immediate), the address is `src_a` + (`imm_field` − 15). Field value 0 gives −15, field value 15 gives 0 and field value 31 gives +16.
- R4: With `req_mode` = 2'b01 (register plus register), the address is `src_a` + `src_b`.
- R5: With `req_mode` = 2'b10 (base-pointer displacement), the address is the base pointer plus `bp_disp` sign-extended from 8 bits, which covers −128 to +127.
- R6: Every sum is taken modulo 2^16. A sum that wraps is not flagged.
- R7: When `bp_wr_en` is 1 on a rising edge, the base pointer takes `bp_wr_data` at that edge. A base-pointer request on the same edge still uses the old value, and requests on later edges use the new one.
- R8: `req_mode` = 2'b11 is reserved. A request with this mode gives `ea_valid` = 0 on the next cycle and leaves `ea_addr` unchanged.
- R9: When `req_valid` is 0, `ea_valid` is 0 on the next cycle and `ea_addr` keeps its value. Base-pointer writes are still taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 2 | Addressing form: 00 reg+imm, 01 reg+reg, 10 base pointer, 11 reserved |
| src_a | input | 16 | First register operand (base register) |
| src_b | input | 16 | Second register operand, used in reg+reg form |
| imm_field | input | 5 | Biased immediate, offset = field − 15 |
| bp_disp | input | 8 | Signed displacement for the base-pointer form |
| bp_wr_en | input | 1 | Load the base pointer |
| bp_wr_data | input | 16 | New base-pointer value |
| ea_valid | output | 1 | Registered: `ea_addr` holds a fresh address |
| ea_addr | output | 16 | Registered effective address |

## Verification
The embedded properties assume the inputs carry known values at every sampled edge, and that `req_mode` = 2'b11 is the only encoding outside the three forms. The stimulus drives every input on the falling edge and never leaves one undriven. The reference model treats the reserved mode as a request that yields nothing. Random sequences mix all four mode encodings, idle cycles and base-pointer writes, including writes that land on the same edge as a base-pointer request. Directed cases cover both ends of the immediate field and of the displacement, as well as sums that wrap past 0xFFFF or below zero.

// File: rtl/lsea_pkg.sv
package lsea_pkg;
  typedef enum logic [1:0] {
    EA_REG_IMM = 2'b00,
    EA_REG_REG = 2'b01,
    EA_BP_DISP = 2'b10,
    EA_RSVD    = 2'b11
  } ea_mode_e;
endpackage

// File: rtl/lsea_bp_reg.sv
module lsea_bp_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] bp_q
);
  always_ff @(posedge clk) begin
    if (rst) bp_q <= '0;
    else if (wr_en) bp_q <= wr_data;
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  // R7
  bp_load_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(wr_en) |-> bp_q == $past(wr_data));
  // R9
  bp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(wr_en) |-> $stable(bp_q));
endmodule

// File: rtl/lsea_operand_sel.sv
module lsea_operand_sel
  import lsea_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int IMM_W    = 5,
  parameter int IMM_BIAS = 15,
  parameter int DISP_W   = 8
) (
  input  ea_mode_e          mode,
  input  logic [ADDR_W-1:0] src_a,
  input  logic [ADDR_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm_field,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] bp,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] addend,
  output logic              legal
);
  localparam logic [ADDR_W-1:0] BIAS_V = ADDR_W'(IMM_BIAS);

  logic [ADDR_W-1:0] imm_ext;
  logic [ADDR_W-1:0] imm_off;
  logic [ADDR_W-1:0] disp_ext;

  generate
    if (ADDR_W > IMM_W) begin : g_imm_pad
      assign imm_ext = {{(ADDR_W-IMM_W){1'b0}}, imm_field};
    end else begin : g_imm_trunc
      assign imm_ext = imm_field[ADDR_W-1:0];
    end
    if (ADDR_W > DISP_W) begin : g_disp_sext
      assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    end else begin : g_disp_trunc
      assign disp_ext = disp[ADDR_W-1:0];
    end
  endgenerate

  assign imm_off = imm_ext - BIAS_V;

  always_comb begin
    base   = src_a;
    addend = imm_off;
    legal  = 1'b1;
    unique case (mode)
      EA_REG_IMM: begin base = src_a; addend = imm_off;  end
      EA_REG_REG: begin base = src_a; addend = src_b;    end
      EA_BP_DISP: begin base = bp;    addend = disp_ext; end
      default:    begin legal = 1'b0;                    end
    endcase
  end
endmodule

// File: rtl/lsea_wrap_add.sv
module lsea_wrap_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  logic [W:0] full;
  assign full = {1'b0, a} + {1'b0, b};
  assign sum  = full[W-1:0];
endmodule

// File: rtl/lsea_top.sv
module lsea_top
  import lsea_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int IMM_W    = 5,
  parameter int IMM_BIAS = 15,
  parameter int DISP_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic [ADDR_W-1:0] src_a,
  input  logic [ADDR_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm_field,
  input  logic [DISP_W-1:0] bp_disp,
  input  logic              bp_wr_en,
  input  logic [ADDR_W-1:0] bp_wr_data,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea_addr
);
  ea_mode_e          mode;
  logic [ADDR_W-1:0] bp_q;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] addend;
  logic [ADDR_W-1:0] sum;
  logic              legal;
  logic              take;

  assign mode = ea_mode_e'(req_mode);

  lsea_bp_reg #(.ADDR_W(ADDR_W)) u_bp (
    .clk(clk), .rst(rst), .wr_en(bp_wr_en), .wr_data(bp_wr_data), .bp_q(bp_q)
  );

  lsea_operand_sel #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .IMM_BIAS(IMM_BIAS), .DISP_W(DISP_W)
  ) u_sel (
    .mode(mode), .src_a(src_a), .src_b(src_b), .imm_field(imm_field),
    .disp(bp_disp), .bp(bp_q), .base(base), .addend(addend), .legal(legal)
  );

  lsea_wrap_add #(.W(ADDR_W)) u_add (.a(base), .b(addend), .sum(sum));

  assign take = req_valid && legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_valid <= 1'b0;
      ea_addr  <= '0;
    end else begin
      ea_valid <= take;
      if (take) ea_addr <= sum;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  // R2
  valid_track_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ea_valid == $past(req_valid && req_mode != 2'b11));
  // R8
  rsvd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(req_mode == 2'b11) |-> !ea_valid && $stable(ea_addr));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(req_valid) |-> !ea_valid && $stable(ea_addr));
  // R4
  regreg_sum_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(req_valid && req_mode == 2'b01) |->
      ea_addr == ADDR_W'($past(src_a) + $past(src_b)));
  // R1
  reset_out_chk: assert property (@(posedge clk)
    $past(rst) |-> !ea_valid && ea_addr == '0);
endmodule

// File: tb/lsea_top_tb.sv
module lsea_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_mode = 2'b00;
  logic [15:0] src_a = '0, src_b = '0, bp_wr_data = '0;
  logic [4:0]  imm_field = '0;
  logic [7:0]  bp_disp = '0;
  logic        bp_wr_en = 1'b0;
  logic        ea_valid;
  logic [15:0] ea_addr;

  int n_tests = 0, n_fail = 0;
  int m_bp = 0, m_addr = 0, m_valid = 0;
  string m_req = "R1";

  always #2 clk = ~clk;

  lsea_top u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .src_a(src_a), .src_b(src_b), .imm_field(imm_field), .bp_disp(bp_disp),
    .bp_wr_en(bp_wr_en), .bp_wr_data(bp_wr_data),
    .ea_valid(ea_valid), .ea_addr(ea_addr)
  );

  task automatic compare(string req);
    n_tests++;
    if (ea_valid !== m_valid[0] || ea_addr !== m_addr[15:0]) begin
      n_fail++;
      $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
               req, ea_valid, ea_addr, m_valid[0], m_addr[15:0]);
    end
  endtask

  // one cycle: drive, model the edge, check after it
  task automatic step(bit v, bit [1:0] md, int a, int b, int imm, int d,
                      bit we, int wd);
    int disp_s;
    req_valid = v; req_mode = md; src_a = a[15:0]; src_b = b[15:0];
    imm_field = imm[4:0]; bp_disp = d[7:0]; bp_wr_en = we; bp_wr_data = wd[15:0];
    @(posedge clk);
    disp_s = (d[7] ? d[7:0] - 256 : d[7:0]);
    if (!v) begin m_valid = 0; m_req = "R9"; end
    else if (md == 2'b11) begin m_valid = 0; m_req = "R8"; end
    else begin
      m_valid = 1;
      case (md)
        2'b00: begin m_addr = (a[15:0] + imm[4:0] - 15) & 16'hFFFF; m_req = "R3"; end
        2'b01: begin m_addr = (a[15:0] + b[15:0]) & 16'hFFFF;       m_req = "R4"; end
        default: begin m_addr = (m_bp + disp_s) & 16'hFFFF;         m_req = "R5"; end
      endcase
    end
    if (we) m_bp = wd & 16'hFFFF;  // R7: old value used by same-edge request
    @(negedge clk);
    compare(m_req);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        compare("R1");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        compare("R1");
        step(1, 2'b10, 0, 0, 0, 0, 0, 0);            // R1 bp reset value
        step(1, 2'b00, 16'h1000, 0, 0, 0, 0, 0);     // R3 field 0 -> -15
        step(1, 2'b00, 16'h1000, 0, 31, 0, 0, 0);    // R3 field 31 -> +16
        step(1, 2'b00, 16'h1000, 0, 15, 0, 0, 0);    // R3 field 15 -> 0
        step(1, 2'b00, 16'h0003, 0, 0, 0, 0, 0);     // R6 wrap below zero
        step(1, 2'b01, 16'hFFFF, 16'h0002, 0, 0, 0, 0); // R6 wrap, R4
        step(1, 2'b01, 16'h1234, 16'h0100, 0, 0, 0, 0); // R4
        step(0, 2'b00, 16'h5555, 0, 3, 0, 1, 16'h8000); // R9 idle + bp write
        step(1, 2'b10, 0, 0, 0, 8'h80, 0, 0);        // R5 disp -128
        step(1, 2'b10, 0, 0, 0, 8'h7F, 1, 16'hFFF0); // R7 same-edge old bp
        step(1, 2'b10, 0, 0, 0, 8'h20, 0, 0);        // R7 new bp, R6 wrap
        step(1, 2'b11, 16'h4444, 1, 0, 0, 0, 0);     // R8 reserved
        step(1, 2'b01, 16'h0010, 16'h0020, 0, 0, 0, 0); // R2 back to back
        for (int i = 0; i < 2000; i++)
          step($urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)),
               int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
               int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
               $urandom_range(0, 4) == 0, int'($urandom_range(0, 65535)));
      end
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule